// File: doc/BRIEF.md
# GPIO Pin Channel Unit

This unit gives a 32-pin GPIO port a set of eight programmable channels. Each channel is bound to one pin of the port through its configuration word and works in one of two modes. In edge-watch mode it follows the pin's level and sets a sticky event flag when the chosen kind of transition appears. In pin-drive mode it takes the pin away from the ordinary output register and drives it itself. A write to the channel's trigger word sets, clears or toggles the pin.

A separate port event flag records rising edges of a port-wide sense input. One interrupt line combines the channel flags and the port flag through an enable mask. Software programs the mask with write-one-to-set and write-one-to-clear words. All control goes through a plain word-addressed register port. Writes take effect on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`. No data stream crosses the block's edge, so it has no valid/ready handshake. Toward the port, the unit takes raw pin levels and returns a per-pin override enable and override value.

Top module: `pin_chan_unit`

## Requirements
- R1: After reset every configuration word, event flag, the port flag and the enable mask read 0, no pin is overridden and `irq_o` is low.
- R2: Word addresses (byte offset / 4): trigger of channel n at n, event flag of channel n at 0x40+n, port flag at 0x5F, enable-set at 0xC1, enable-clear at 0xC2, configuration of channel n at 0x144+n. The configuration word holds mode in bits [1:0], pin select in [13:8], polarity in [17:16] and the initial drive in bit 20. The word reads back with all other bits 0.
- R3: Mode value 1 is edge-watch. With polarity 1 the flag sets on a 0-to-1 transition of the selected pin only. Pin levels pass two synchronizer stages, so the flag reads 1 from the third clock edge after the pin change.
- R4: In edge-watch mode, polarity 2 flags only 1-to-0 transitions, polarity 3 flags both kinds, and polarity 0 flags nothing.
- R5: An event flag reads 1 once set and keeps that value until software writes 0 to bit 0 of its word.
- R6: Mode value 3 is pin-drive. The selected pin's override enable is 1. Every configuration write in this mode loads bit 20 into the driven value.
- R7: A trigger write with bit 0 = 1 to a pin-drive channel sets the pin for polarity 1, clears it for polarity 2, inverts it for polarity 3, and leaves it unchanged for polarity 0. A trigger write with bit 0 = 0 does nothing. Trigger words always read 0.
- R8: When several pin-drive channels select the same pin, the lowest-numbered channel supplies the override value.
- R9: Pin-select bit 13 is the port number. A channel whose port bit differs from the unit's port (0 by default) neither overrides a pin nor flags events.
- R10: Mode values 0 and 2 leave the channel idle: no override and no events. Edge-watch mode never overrides a pin.
- R11: Enable bit n (n < 8) gates channel n and bit 31 gates the port flag. Writing 1s to the set word enables those sources and writing 1s to the clear word disables them. Both words read back the current mask.
- R12: `irq_o` is high exactly when some set flag has its enable bit set.
- R13: The port flag sets on a rising edge of `port_sense_i`, with the same latency as R3, and clears when 0 is written to its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_lvl_i | input | 32 | Raw pin levels from the port |
| port_sense_i | input | 1 | Port-wide sense input |
| ovr_en_o | output | 32 | Per-pin override enable |
| ovr_val_o | output | 32 | Per-pin override value, 0 where not overridden |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench drives a pin in the direction a channel must ignore and checks that its flag stays clear. A design that detected levels rather than transitions, or mixed up the polarity codes, would set the flag there. It reloads pin-drive channels with each polarity and initial value and fires triggers, including a zero-data trigger. A wrong decode would move the pin, or would leave the pin unchanged when it should move. Two channels are stacked on one pin to check that the lower index wins. A reversed priority would show the other channel's value. A foreign-port selector, the idle mode codes and the interrupt mask (set, clear, readback, bit 31) are also exercised. A design that ignored the port bit would override a pin it does not own, and a wrong mask would raise an interrupt that should stay low.

// File: rtl/pin_chan_pkg.sv
`timescale 1ns/1ps
package pin_chan_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_EVT = 2'd1,
    MODE_RSV = 2'd2,
    MODE_TSK = 2'd3
  } chan_mode_e;

  typedef enum logic [1:0] {
    POL_NONE = 2'd0,
    POL_RISE = 2'd1,
    POL_FALL = 2'd2,
    POL_ANY  = 2'd3
  } chan_pol_e;

  typedef struct packed {
    logic       init;
    chan_pol_e  pol;
    logic [5:0] psel;
    chan_mode_e mode;
  } chan_cfg_t;

  // word addresses of the register port
  localparam int WA_TASK     = 0;
  localparam int WA_EVT      = 64;
  localparam int WA_PORT_EVT = 95;
  localparam int WA_EN_SET   = 193;
  localparam int WA_EN_CLR   = 194;
  localparam int WA_CFG      = 324;

  function automatic chan_cfg_t cfg_from_word(input logic [31:0] w);
    chan_cfg_t c;
    c.mode = chan_mode_e'(w[1:0]);
    c.psel = w[13:8];
    c.pol  = chan_pol_e'(w[17:16]);
    c.init = w[20];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(input chan_cfg_t c);
    logic [31:0] w;
    w        = '0;
    w[1:0]   = c.mode;
    w[13:8]  = c.psel;
    w[17:16] = c.pol;
    w[20]    = c.init;
    return w;
  endfunction

endpackage

// File: rtl/pin_chan_sync.sv
`timescale 1ns/1ps
module pin_chan_sync #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] now_o,
  output logic [W-1:0] was_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      now_o  <= '0;
      was_o  <= '0;
    end else begin
      meta_q <= raw_i;
      now_o  <= meta_q;
      was_o  <= now_o;
    end
  end
endmodule

// File: rtl/pin_chan_slot.sv
`timescale 1ns/1ps
module pin_chan_slot
  import pin_chan_pkg::*;
#(
  parameter int PINS    = 32,
  parameter int PORT_ID = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we_i,
  input  logic [31:0]              cfg_wdata_i,
  input  logic                     fire_i,
  input  logic                     ev_we_i,
  input  logic                     ev_wdata_i,
  input  logic [PINS-1:0]          now_i,
  input  logic [PINS-1:0]          was_i,
  output logic [31:0]              cfg_word_o,
  output logic                     ev_o,
  output logic                     own_o,
  output logic [$clog2(PINS)-1:0]  idx_o,
  output logic                     drv_o
);
  localparam int PIN_W = $clog2(PINS);

  chan_cfg_t cfg_q;
  chan_cfg_t cfg_new;
  logic      ev_q, drv_q;
  logic      on_port, rise, fall, hit;
  logic [PIN_W-1:0] idx;

  assign cfg_new = cfg_from_word(cfg_wdata_i);
  assign idx     = cfg_q.psel[PIN_W-1:0];
  assign on_port = (cfg_q.psel[5] == 1'(PORT_ID));
  assign rise    = now_i[idx] & ~was_i[idx];
  assign fall    = ~now_i[idx] & was_i[idx];

  always_comb begin
    hit = 1'b0;
    if (cfg_q.mode == MODE_EVT && on_port) begin
      case (cfg_q.pol)
        POL_RISE: hit = rise;
        POL_FALL: hit = fall;
        POL_ANY:  hit = rise | fall;
        default:  hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ev_q  <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_new;
      if (hit) ev_q <= 1'b1;
      else if (ev_we_i) ev_q <= ev_wdata_i;
      if (cfg_we_i && cfg_new.mode == MODE_TSK) begin
        drv_q <= cfg_new.init;
      end else if (fire_i && cfg_q.mode == MODE_TSK) begin
        case (cfg_q.pol)
          POL_RISE: drv_q <= 1'b1;
          POL_FALL: drv_q <= 1'b0;
          POL_ANY:  drv_q <= ~drv_q;
          default:  drv_q <= drv_q;
        endcase
      end
    end
  end

  assign cfg_word_o = cfg_to_word(cfg_q);
  assign ev_o       = ev_q;
  assign own_o      = (cfg_q.mode == MODE_TSK) && on_port;
  assign idx_o      = idx;
  assign drv_o      = drv_q;
endmodule

// File: rtl/pin_chan_arb.sv
`timescale 1ns/1ps
module pin_chan_arb #(
  parameter int CHANS = 8,
  parameter int PINS  = 32
) (
  input  logic [CHANS-1:0]              own_i,
  input  logic [CHANS*$clog2(PINS)-1:0] idx_i,
  input  logic [CHANS-1:0]              drv_i,
  output logic [PINS-1:0]               en_o,
  output logic [PINS-1:0]               val_o
);
  localparam int PIN_W = $clog2(PINS);

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic en, val;
    always_comb begin
      en  = 1'b0;
      val = 1'b0;
      // walk downward so the lowest-numbered owner is applied last
      for (int c = CHANS - 1; c >= 0; c--) begin
        if (own_i[c] && idx_i[c*PIN_W +: PIN_W] == PIN_W'(p)) begin
          en  = 1'b1;
          val = drv_i[c];
        end
      end
    end
    assign en_o[p]  = en;
    assign val_o[p] = val;
  end
endmodule

// File: rtl/pin_chan_unit.sv
`timescale 1ns/1ps
module pin_chan_unit
  import pin_chan_pkg::*;
#(
  parameter int CHANS   = 8,
  parameter int PINS    = 32,
  parameter int PORT_ID = 0,
  parameter int AW      = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [PINS-1:0] pin_lvl_i,
  input  logic            port_sense_i,
  output logic [PINS-1:0] ovr_en_o,
  output logic [PINS-1:0] ovr_val_o,
  output logic            irq_o
);
  localparam int PIN_W = $clog2(PINS);

  logic [PINS:0]          now_s, was_s;
  logic [CHANS-1:0]       ev, own, drv;
  logic [CHANS*PIN_W-1:0] idx;
  logic [31:0]            cfg_w [CHANS];
  logic [CHANS:0]         inten_q;
  logic                   port_ev_q;
  logic                   wr_set, wr_clr, wr_port;
  logic [CHANS:0]         wmask;

  pin_chan_sync #(.W(PINS + 1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i ({port_sense_i, pin_lvl_i}),
    .now_o (now_s),
    .was_o (was_s)
  );

  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    pin_chan_slot #(.PINS(PINS), .PORT_ID(PORT_ID)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we_i    (bus_we && bus_addr == AW'(WA_CFG + c)),
      .cfg_wdata_i (bus_wdata),
      .fire_i      (bus_we && bus_addr == AW'(WA_TASK + c) && bus_wdata[0]),
      .ev_we_i     (bus_we && bus_addr == AW'(WA_EVT + c)),
      .ev_wdata_i  (bus_wdata[0]),
      .now_i       (now_s[PINS-1:0]),
      .was_i       (was_s[PINS-1:0]),
      .cfg_word_o  (cfg_w[c]),
      .ev_o        (ev[c]),
      .own_o       (own[c]),
      .idx_o       (idx[c*PIN_W +: PIN_W]),
      .drv_o       (drv[c])
    );
  end

  pin_chan_arb #(.CHANS(CHANS), .PINS(PINS)) u_arb (
    .own_i (own),
    .idx_i (idx),
    .drv_i (drv),
    .en_o  (ovr_en_o),
    .val_o (ovr_val_o)
  );

  assign wr_set  = bus_we && bus_addr == AW'(WA_EN_SET);
  assign wr_clr  = bus_we && bus_addr == AW'(WA_EN_CLR);
  assign wr_port = bus_we && bus_addr == AW'(WA_PORT_EVT);
  assign wmask   = {bus_wdata[31], bus_wdata[CHANS-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inten_q   <= '0;
      port_ev_q <= 1'b0;
    end else begin
      if (wr_set) inten_q <= inten_q | wmask;
      else if (wr_clr) inten_q <= inten_q & ~wmask;
      if (now_s[PINS] && !was_s[PINS]) port_ev_q <= 1'b1;
      else if (wr_port) port_ev_q <= bus_wdata[0];
    end
  end

  assign irq_o = |({port_ev_q, ev} & inten_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(WA_PORT_EVT)) bus_rdata[0] = port_ev_q;
    if (bus_addr == AW'(WA_EN_SET) || bus_addr == AW'(WA_EN_CLR)) begin
      bus_rdata[CHANS-1:0] = inten_q[CHANS-1:0];
      bus_rdata[31]        = inten_q[CHANS];
    end
    for (int c = 0; c < CHANS; c++) begin
      if (bus_addr == AW'(WA_EVT + c)) bus_rdata[0] = ev[c];
      if (bus_addr == AW'(WA_CFG + c)) bus_rdata = cfg_w[c];
    end
  end
endmodule

// File: rtl/pin_chan_chk.sv
`timescale 1ns/1ps
module pin_chan_chk
  import pin_chan_pkg::*;
#(
  parameter int CHANS = 8,
  parameter int PINS  = 32,
  parameter int AW    = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [31:0]     bus_wdata,
  input logic [31:0]     bus_rdata,
  input logic [PINS-1:0] ovr_en,
  input logic [PINS-1:0] ovr_val,
  input logic            irq,
  input logic [CHANS:0]  inten
);
  // R7: trigger words read as zero
  a_r7_trigger_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(WA_TASK)) |-> (bus_rdata == 32'd0));

  // R11: set word enables the named source on the next cycle
  a_r11_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(WA_EN_SET) && bus_wdata[0]) |=> inten[0]);

  // R11: clear word disables the port source on the next cycle
  a_r11_clear_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(WA_EN_CLR) && bus_wdata[31]) |=> !inten[CHANS]);

  // R12: no interrupt while the whole mask is off
  a_r12_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (inten == '0) |-> !irq);

  // R6: an override value only appears on an owned pin
  a_r6_value_needs_owner: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovr_val & ~ovr_en) == '0));
endmodule

bind pin_chan_unit pin_chan_chk #(.CHANS(CHANS), .PINS(PINS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .ovr_en    (ovr_en_o),
  .ovr_val   (ovr_val_o),
  .irq       (irq_o),
  .inten     (inten_q)
);

// File: tb/pin_chan_unit_test.sv
`timescale 1ns/1ps
module pin_chan_unit_test;
  localparam int AW = 10;
  localparam logic [AW-1:0] A_EVT = 10'h040, A_PEV = 10'h05F,
                            A_SET = 10'h0C1, A_CLR = 10'h0C2, A_CFG = 10'h144;
  localparam int K_RD = 0, K_EN = 1, K_VAL = 2, K_IRQ = 3;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, sense = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pins = '0, ovr_en, ovr_val;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pin_chan_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_lvl_i(pins),
    .port_sense_i(sense), .ovr_en_o(ovr_en), .ovr_val_o(ovr_val), .irq_o(irq)
  );

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    item_t it;
    logic [31:0] act;
    while (sb.size() > 0) begin
      it = sb.pop_front();
      case (it.kind)
        K_RD:    act = bus_rdata;
        K_EN:    act = ovr_en;
        K_VAL:   act = ovr_val;
        default: act = {31'd0, irq};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [31:0] cfg(input int mode, input int psel, input int pol, input int init);
    return 32'(mode) | (32'(psel) << 8) | (32'(pol) << 16) | (32'(init) << 20);
  endfunction

  task automatic expect_val(input int kind, input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); #1;
    bus_addr = a;
    sb.push_back('{kind: kind, exp: e, tag: tag});
    wait (sb.size() == 0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk); #1;
    pins[p] = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_val(K_RD, A_CFG, 0, "R1 cfg0 after reset");
    expect_val(K_RD, A_EVT, 0, "R1 flag0 after reset");
    expect_val(K_RD, A_SET, 0, "R1 mask after reset");
    expect_val(K_EN, 0, 0, "R1 no override after reset");
    expect_val(K_IRQ, 0, 0, "R1 irq low after reset");

    // R3 rising edge on channel 0, pin 3
    wr(A_CFG + 0, cfg(1, 3, 1, 0));
    expect_val(K_EN, 0, 0, "R10 edge-watch leaves pins alone");
    set_pin(3, 1'b1);
    expect_val(K_RD, A_EVT + 0, 1, "R3 rising edge flagged");
    wr(A_EVT + 0, 0);
    expect_val(K_RD, A_EVT + 0, 0, "R5 flag cleared by writing 0");
    set_pin(3, 1'b0);
    expect_val(K_RD, A_EVT + 0, 0, "R3 falling edge ignored by rise polarity");

    // R4 other polarities
    wr(A_CFG + 1, cfg(1, 5, 2, 0));
    set_pin(5, 1'b1);
    expect_val(K_RD, A_EVT + 1, 0, "R4 fall polarity ignores rise");
    set_pin(5, 1'b0);
    expect_val(K_RD, A_EVT + 1, 1, "R4 fall polarity flags fall");
    wr(A_CFG + 2, cfg(1, 6, 3, 0));
    set_pin(6, 1'b1);
    expect_val(K_RD, A_EVT + 2, 1, "R4 any polarity flags rise");
    wr(A_EVT + 2, 0);
    set_pin(6, 1'b0);
    expect_val(K_RD, A_EVT + 2, 1, "R4 any polarity flags fall");
    wr(A_EVT + 2, 0);
    wr(A_CFG + 3, cfg(1, 7, 0, 0));
    set_pin(7, 1'b1);
    set_pin(7, 1'b0);
    expect_val(K_RD, A_EVT + 3, 0, "R4 polarity 0 flags nothing");

    // R11 / R12 interrupt mask (channel 1 flag is set)
    expect_val(K_IRQ, 0, 0, "R12 masked flag gives no irq");
    wr(A_SET, 32'h2);
    expect_val(K_IRQ, 0, 1, "R12 enabled flag raises irq");
    expect_val(K_RD, A_SET, 32'h2, "R11 set word reads mask");
    expect_val(K_RD, A_CLR, 32'h2, "R11 clear word reads mask");
    wr(A_CLR, 32'h2);
    expect_val(K_IRQ, 0, 0, "R11 cleared enable drops irq");
    expect_val(K_RD, A_SET, 0, "R11 mask empty after clear");

    // R6 / R7 pin-drive on channel 4, pin 10
    wr(A_CFG + 4, cfg(3, 10, 1, 0));
    expect_val(K_EN, 0, 32'h400, "R6 pin-drive owns pin 10");
    expect_val(K_VAL, 0, 0, "R6 initial value 0");
    wr(4, 1);
    expect_val(K_VAL, 0, 32'h400, "R7 set polarity drives 1");
    expect_val(K_RD, 4, 0, "R7 trigger word reads 0");
    wr(A_CFG + 4, cfg(3, 10, 2, 1));
    expect_val(K_VAL, 0, 32'h400, "R6 initial value 1 loaded");
    wr(4, 1);
    expect_val(K_VAL, 0, 0, "R7 clear polarity drives 0");
    wr(A_CFG + 4, cfg(3, 10, 3, 0));
    wr(4, 1);
    expect_val(K_VAL, 0, 32'h400, "R7 toggle to 1");
    wr(4, 1);
    expect_val(K_VAL, 0, 0, "R7 toggle back to 0");
    wr(4, 0);
    expect_val(K_VAL, 0, 0, "R7 zero trigger has no effect");
    wr(A_CFG + 4, cfg(3, 10, 0, 1));
    wr(4, 1);
    expect_val(K_VAL, 0, 32'h400, "R7 polarity 0 keeps value");

    // R8 priority
    wr(A_CFG + 4, cfg(3, 10, 0, 0));
    wr(A_CFG + 5, cfg(3, 10, 0, 1));
    expect_val(K_VAL, 0, 0, "R8 lower channel wins");
    wr(A_CFG + 4, cfg(0, 10, 0, 0));
    expect_val(K_VAL, 0, 32'h400, "R8 remaining owner drives");
    expect_val(K_EN, 0, 32'h400, "R10 idle channel releases nothing else");

    // R9 foreign port
    wr(A_CFG + 6, cfg(3, 44, 0, 1));
    expect_val(K_EN, 0, 32'h400, "R9 foreign port channel owns nothing");
    wr(A_CFG + 7, cfg(1, 45, 3, 0));
    set_pin(13, 1'b1);
    expect_val(K_RD, A_EVT + 7, 0, "R9 foreign port channel flags nothing");

    // R13 port flag
    wr(A_SET, 32'h8000_0000);
    expect_val(K_RD, A_SET, 32'h8000_0000, "R11 bit 31 enable");
    expect_val(K_IRQ, 0, 0, "R12 irq low before port event");
    @(negedge clk); #1; sense = 1'b1;
    repeat (4) @(negedge clk);
    expect_val(K_RD, A_PEV, 1, "R13 port flag set");
    expect_val(K_IRQ, 0, 1, "R12 port flag raises irq");
    wr(A_PEV, 0);
    expect_val(K_RD, A_PEV, 0, "R13 port flag cleared");
    expect_val(K_IRQ, 0, 0, "R12 irq drops with port flag");

    // R10 idle channel, R2 readback
    wr(A_CFG + 0, 0);
    set_pin(3, 1'b1);
    expect_val(K_RD, A_EVT + 0, 0, "R10 disabled channel flags nothing");
    wr(A_CFG + 2, cfg(2, 3, 3, 0));
    set_pin(3, 1'b0);
    expect_val(K_RD, A_EVT + 2, 0, "R10 mode 2 flags nothing");
    wr(A_CFG + 3, 32'hFFFF_FFFF);
    expect_val(K_RD, A_CFG + 3, 32'h0013_3F03, "R2 config readback mask");
    expect_val(K_EN, 0, 32'h400, "R9 port bit 1 channel owns nothing");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule